// File: doc/BRIEF.md
# Word Multiply Unit

This unit performs the integer multiplies of an execution pipeline. Each operation takes two 64-bit register operands, a 16-bit immediate and an operation code. It returns a 64-bit result. For the overflow-checking form it also returns the overflow flag and the new overflow and summary-overflow state. When recording is requested, it returns a 4-bit condition field. Operand decode and register-file access stay outside the unit.

The multiplier is a pipeline with a fixed depth of `LATENCY` stages. It uses a valid/ready handshake on both sides. The whole pipeline advances together whenever the output stage is empty or is being taken. Because the operand selection is set per operation, one 64x64 low-half multiplier covers all four operations.

Top module: `word_mul_unit`

## Requirements
- R1: With `op_i` = 2'b00 (low word), `res_o` is the full 64-bit product of `ra_i[31:0]` and `rb_i[31:0]`, both sign-extended. Bits 63:32 of the operands have no effect.
- R2: The low-word overflow flag `ovf_o` is 1 when the product differs from its own bits 31:0 sign-extended to 64 bits. With `oe_i` set, `ov_we_o` is 1, `ov_o` and `ov32_o` both equal the flag, and `so_o` = `so_i` OR flag. With `oe_i` clear, `ov_we_o` is 0 and `so_o` = `so_i`.
- R3: With `op_i` = 2'b01 (high word signed), `res_o` holds bits 63:32 of the signed product of the low 32-bit halves in bits 31:0, and zero in bits 63:32.
- R4: With `op_i` = 2'b10 (high word unsigned), `res_o` is formed the same way as in R3, but from the product of the zero-extended low halves.
- R5: With `op_i` = 2'b11 (immediate), `res_o` is the low 64 bits of the product of all of `ra_i` and `imm_i` sign-extended to 64 bits.
- R6: The high-word and immediate operations never flag overflow. For them, `ovf_o`, `ov_we_o`, `ov_o` and `ov32_o` are 0 and `so_o` = `so_i`, whatever `oe_i` is.
- R7: For the three register operations, `cr_we_o` equals `rec_i`. The immediate operation ignores `rec_i` and gives `cr_we_o` = 0. The field `cr_o` is {lt, gt, eq, so}. The bits lt, gt and eq come from a 64-bit signed compare of `res_o` with zero, and so is the updated `so_o`.
- R8: With `out_ready_i` held high, an operation accepted at a clock edge appears on the output `LATENCY` edges later (default 3). Results leave in the order they were accepted.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the output stays valid and unchanged and `in_ready_o` is 0.
- R10: During reset `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The unit accepts an operation this cycle |
| op_i | input | 2 | 00 low word, 01 high signed, 10 high unsigned, 11 immediate |
| oe_i | input | 1 | Overflow-checking form |
| rec_i | input | 1 | Record the condition field |
| so_i | input | 1 | Current summary-overflow bit |
| ra_i | input | 64 | First register operand |
| rb_i | input | 64 | Second register operand |
| imm_i | input | 16 | Signed immediate |
| out_valid_o | output | 1 | A result is presented |
| out_ready_i | input | 1 | The consumer takes the result |
| res_o | output | 64 | Result |
| ovf_o | output | 1 | Raw low-word overflow flag |
| ov_we_o | output | 1 | Write overflow bits |
| ov_o | output | 1 | New 64-bit overflow bit |
| ov32_o | output | 1 | New 32-bit overflow bit |
| so_o | output | 1 | New summary-overflow bit |
| cr_we_o | output | 1 | Write condition field |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
An overflow and a condition-field record can happen in the same result. In that case the so bit in `cr_o` must reflect the summary bit that was just set, not the incoming `so_i`. The bench provokes this with a low-word multiply of 0x80000000 by itself, with `oe_i` and `rec_i` set and `so_i` clear. The expected field is gt together with so. Random streams under random back-pressure also mix these cases with stalls, and the scoreboard judges each result against the model.

// File: rtl/wmu_pkg.sv
package wmu_pkg;

  typedef enum logic [1:0] {
    OP_MUL_LW  = 2'b00,
    OP_MUL_HW  = 2'b01,
    OP_MUL_HWU = 2'b10,
    OP_MUL_LI  = 2'b11
  } wmu_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } wmu_crf_t;

  // control bits carried down the pipe: {op, oe, rec, so}
  localparam int unsigned CTL_W = 5;

endpackage

// File: rtl/wmu_operand_prep.sv
module wmu_operand_prep
  import wmu_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned WORD  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  wmu_op_e          op_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  opa_o,
  output logic [XLEN-1:0]  opb_o
);

  localparam int unsigned EXT_W = XLEN - WORD;
  localparam int unsigned IEXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] ra_sx, rb_sx, ra_zx, rb_zx, imm_sx;

  assign ra_sx  = {{EXT_W{ra_i[WORD-1]}}, ra_i[WORD-1:0]};
  assign rb_sx  = {{EXT_W{rb_i[WORD-1]}}, rb_i[WORD-1:0]};
  assign ra_zx  = {{EXT_W{1'b0}}, ra_i[WORD-1:0]};
  assign rb_zx  = {{EXT_W{1'b0}}, rb_i[WORD-1:0]};
  assign imm_sx = {{IEXT_W{imm_i[IMM_W-1]}}, imm_i};

  // low 64 bits of an XLEN x XLEN product are sign-agnostic, so extension picks the variant
  always_comb begin
    unique case (op_i)
      OP_MUL_LW, OP_MUL_HW: begin
        opa_o = ra_sx;
        opb_o = rb_sx;
      end
      OP_MUL_HWU: begin
        opa_o = ra_zx;
        opb_o = rb_zx;
      end
      default: begin
        opa_o = ra_i;
        opb_o = imm_sx;
      end
    endcase
  end

endmodule

// File: rtl/wmu_mul_pipe.sv
module wmu_mul_pipe #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned LATENCY = 3,
  parameter int unsigned CTL_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             in_valid_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  output logic             out_valid_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [XLEN-1:0]  prod_o
);

  localparam int unsigned LAST = LATENCY - 1;

  logic [LATENCY-1:0] vld_q;
  logic [LATENCY:0]   vld_chain;
  logic [CTL_W-1:0]   ctl_q  [LATENCY];
  logic [XLEN-1:0]    prod_q [LATENCY];
  logic [XLEN-1:0]    prod_d;

  assign vld_chain = {vld_q, in_valid_i};
  assign prod_d    = opa_i * opb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (advance_i) vld_q <= vld_chain[LATENCY-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (advance_i && in_valid_i) begin
      ctl_q[0]  <= ctl_i;
      prod_q[0] <= prod_d;
    end
  end

  for (genvar s = 1; s < LATENCY; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (advance_i && vld_q[s-1]) begin
        ctl_q[s]  <= ctl_q[s-1];
        prod_q[s] <= prod_q[s-1];
      end
    end
  end

  assign out_valid_o = vld_q[LAST];
  assign ctl_o       = ctl_q[LAST];
  assign prod_o      = prod_q[LAST];

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q[LAST] && !advance_i) |=> (vld_q[LAST] && $stable(prod_q[LAST]) && $stable(ctl_q[LAST])));

endmodule

// File: rtl/wmu_flag_gen.sv
module wmu_flag_gen
  import wmu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input  logic            valid_i,
  input  wmu_op_e         op_i,
  input  logic            oe_i,
  input  logic            rec_i,
  input  logic            so_i,
  input  logic [XLEN-1:0] prod_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o,
  output logic            ov_we_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            so_o,
  output logic            cr_we_o,
  output wmu_crf_t        cr_o
);

  localparam int unsigned EXT_W = XLEN - WORD;

  logic [XLEN-1:0] low_sx;
  logic            is_lw, ovf_set;

  assign low_sx  = {{EXT_W{prod_i[WORD-1]}}, prod_i[WORD-1:0]};
  assign is_lw   = (op_i == OP_MUL_LW);
  assign ovf_o   = is_lw && (prod_i != low_sx);
  assign ov_we_o = valid_i && is_lw && oe_i;
  assign ovf_set = ov_we_o && ovf_o;
  assign ov_o    = ovf_set;
  assign ov32_o  = ovf_set;
  assign so_o    = so_i | ovf_set;

  always_comb begin
    unique case (op_i)
      OP_MUL_HW, OP_MUL_HWU: res_o = {{WORD{1'b0}}, prod_i[XLEN-1:WORD]};
      default:               res_o = prod_i;
    endcase
  end

  assign cr_we_o  = valid_i && rec_i && (op_i != OP_MUL_LI);
  assign cr_o.lt  = res_o[XLEN-1];
  assign cr_o.eq  = (res_o == '0);
  assign cr_o.gt  = !res_o[XLEN-1] && (res_o != '0);
  assign cr_o.so  = so_o;

endmodule

// File: rtl/word_mul_unit.sv
module word_mul_unit
  import wmu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned WORD    = 32,
  parameter int unsigned IMM_W   = 16,
  parameter int unsigned LATENCY = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       op_i,
  input  logic             oe_i,
  input  logic             rec_i,
  input  logic             so_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [XLEN-1:0]  res_o,
  output logic             ovf_o,
  output logic             ov_we_o,
  output logic             ov_o,
  output logic             ov32_o,
  output logic             so_o,
  output logic             cr_we_o,
  output logic [3:0]       cr_o
);

  logic [XLEN-1:0]  opa, opb, prod;
  logic [CTL_W-1:0] ctl_in, ctl_out;
  logic             advance, pipe_vld;
  wmu_op_e          op_in, op_out;
  wmu_crf_t         crf;

  assign op_in   = wmu_op_e'(op_i);
  assign ctl_in  = {op_i, oe_i, rec_i, so_i};
  assign advance = !pipe_vld || out_ready_i;
  assign in_ready_o = advance;

  wmu_operand_prep #(.XLEN(XLEN), .WORD(WORD), .IMM_W(IMM_W)) i_prep (
    .op_i  (op_in),
    .ra_i  (ra_i),
    .rb_i  (rb_i),
    .imm_i (imm_i),
    .opa_o (opa),
    .opb_o (opb)
  );

  wmu_mul_pipe #(.XLEN(XLEN), .LATENCY(LATENCY), .CTL_W(CTL_W)) i_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .advance_i   (advance),
    .in_valid_i  (in_valid_i),
    .ctl_i       (ctl_in),
    .opa_i       (opa),
    .opb_i       (opb),
    .out_valid_o (pipe_vld),
    .ctl_o       (ctl_out),
    .prod_o      (prod)
  );

  assign op_out = wmu_op_e'(ctl_out[4:3]);

  wmu_flag_gen #(.XLEN(XLEN), .WORD(WORD)) i_flags (
    .valid_i (pipe_vld),
    .op_i    (op_out),
    .oe_i    (ctl_out[2]),
    .rec_i   (ctl_out[1]),
    .so_i    (ctl_out[0]),
    .prod_i  (prod),
    .res_o   (res_o),
    .ovf_o   (ovf_o),
    .ov_we_o (ov_we_o),
    .ov_o    (ov_o),
    .ov32_o  (ov32_o),
    .so_o    (so_o),
    .cr_we_o (cr_we_o),
    .cr_o    (crf)
  );

  assign out_valid_o = pipe_vld;
  assign cr_o        = crf;

  assert_ovf_sets_so_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ov_we_o && ov_o) |-> (so_o && ov32_o && ovf_o));

  // R3 and R4 share the upper-half rule
  assert_high_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (op_out == OP_MUL_HW || op_out == OP_MUL_HWU)) |-> (res_o[XLEN-1:WORD] == '0));

  assert_no_ov_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_out != OP_MUL_LW) |-> (!ov_we_o && !ovf_o && !ov_o && !ov32_o));

  assert_cr_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cr_we_o) |-> ($countones(cr_o[3:1]) == 1 && cr_o[0] == so_o));

  assert_no_accept_stalled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && in_valid_i) |=> $stable(res_o));

endmodule

// File: tb/test_word_mul_unit.sv
module test_word_mul_unit;
  import wmu_pkg::*;

  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [1:0]  op_i = 2'b00;
  logic        oe_i = 1'b0, rec_i = 1'b0, so_i = 1'b0;
  logic [63:0] ra_i = '0, rb_i = '0;
  logic [15:0] imm_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] res_o;
  logic        ovf_o, ov_we_o, ov_o, ov32_o, so_o, cr_we_o;
  logic [3:0]  cr_o;

  word_mul_unit #(.LATENCY(LAT)) i_word_mul_unit (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [63:0] res;
    logic [4:0]  flg;   // {ovf, ov_we, ov, ov32, so}
    logic        cr_we;
    logic [3:0]  cr;
    logic [1:0]  op;
    logic [31:0] cyc;
    logic        lat;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cyc = 0, rdy_mode = 0;
  bit   lat_mode = 1'b1, done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rdy_mode == 0) out_ready_i = 1'b1;
    else if (rdy_mode == 1) out_ready_i = 1'($urandom % 2);
    else out_ready_i = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                                 input logic [15:0] imm, input logic oe, input logic rec, input logic so);
    exp_t e;
    logic signed [63:0] sa, sb, p;
    logic [63:0] ua, ub, up;
    logic ovf, we, nso;
    sa = {{32{a[31]}}, a[31:0]};
    sb = {{32{b[31]}}, b[31:0]};
    p  = sa * sb;
    ua = {32'h0, a[31:0]};
    ub = {32'h0, b[31:0]};
    up = ua * ub;
    ovf = 1'b0;
    case (op)
      2'b00: begin e.res = p; ovf = (p != {{32{p[31]}}, p[31:0]}); end
      2'b01: e.res = {32'h0, p[63:32]};
      2'b10: e.res = {32'h0, up[63:32]};
      default: e.res = a * {{48{imm[15]}}, imm};
    endcase
    we  = (op == 2'b00) && oe;
    nso = so | (we & ovf);
    e.flg   = {ovf, we, we & ovf, we & ovf, nso};
    e.cr_we = rec && (op != 2'b11);
    e.cr    = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == 64'h0, nso};
    e.op    = op;
    e.cyc   = 32'(cyc);
    e.lat   = lat_mode;
    return e;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] imm, input logic oe, input logic rec, input logic so);
    @(negedge clk_i);
    op_i = op; ra_i = a; rb_i = b; imm_i = imm; oe_i = oe; rec_i = rec; so_i = so;
    in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    q.push_back(model(op, a, b, imm, oe, rec, so));
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
  endtask

  function automatic string res_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected output", res_o, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_o === e.res, res_tag(e.op), res_o, e.res);
        chk({ovf_o, ov_we_o, ov_o, ov32_o, so_o} === e.flg, (e.op == 2'b00) ? "R2 flags" : "R6 flags",
            64'({ovf_o, ov_we_o, ov_o, ov32_o, so_o}), 64'(e.flg));
        chk(cr_we_o === e.cr_we && (!e.cr_we || cr_o === e.cr), "R7 cr",
            64'({cr_we_o, cr_o}), 64'({e.cr_we, e.cr}));
        if (e.lat) chk(cyc == int'(e.cyc) + LAT, "R8 latency", 64'(cyc), 64'(int'(e.cyc) + LAT));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", q.size(), 0);
    finish_run();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid_o === 1'b0, "R10 valid in reset", 64'(out_valid_o), 64'h0);
    chk(in_ready_o === 1'b1, "R10 ready in reset", 64'(in_ready_o), 64'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1/R2/R7 directed
    issue(2'b00, 64'd3, 64'd5, 16'h0, 1'b1, 1'b1, 1'b0);
    issue(2'b00, 64'h1234_5678_FFFF_FFFE, 64'hDEAD_BEEF_0000_0007, 16'h0, 1'b0, 1'b1, 1'b0);
    // overflow and record in the same result
    issue(2'b00, 64'h8000_0000, 64'h8000_0000, 16'h0, 1'b1, 1'b1, 1'b0);
    issue(2'b00, 64'h7FFF_FFFF, 64'd2, 16'h0, 1'b0, 1'b1, 1'b0);
    issue(2'b00, 64'h0, 64'h55, 16'h0, 1'b1, 1'b1, 1'b1);
    // R3/R4/R6
    issue(2'b01, 64'h8000_0000, 64'h8000_0000, 16'h0, 1'b1, 1'b1, 1'b0);
    issue(2'b01, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 16'h0, 1'b1, 1'b1, 1'b0);
    issue(2'b01, 64'hFFFF_FFFF, 64'd1, 16'h0, 1'b0, 1'b1, 1'b1);
    issue(2'b10, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 16'h0, 1'b1, 1'b1, 1'b0);
    // R5: rec and oe ignored
    issue(2'b11, 64'd100, 64'h0, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    issue(2'b11, 64'h8000_0000_0000_0001, 64'h0, 16'h7FFF, 1'b1, 1'b1, 1'b1);
    repeat (LAT + 2) @(negedge clk_i);

    // random under back-pressure
    lat_mode = 1'b0;
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) a[31:0] = 32'h8000_0000;
      issue(2'($urandom), a, b, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    rdy_mode = 0;
    repeat (LAT + 4) @(negedge clk_i);

    // R9 stall hold
    rdy_mode = 2;
    issue(2'b00, 64'h8000_0000, 64'h8000_0000, 16'h0, 1'b1, 1'b0, 1'b0);
    repeat (LAT) @(negedge clk_i);
    #3;
    held = res_o;
    repeat (3) @(negedge clk_i);
    #3;
    chk(out_valid_o === 1'b1, "R9 valid held", 64'(out_valid_o), 64'h1);
    chk(res_o === held, "R9 result held", res_o, held);
    chk(in_ready_o === 1'b0, "R9 ready low", 64'(in_ready_o), 64'h0);
    rdy_mode = 0;

    while (q.size() != 0) @(negedge clk_i);
    repeat (LAT + 2) @(negedge clk_i);
    #3;
    chk(out_valid_o === 1'b0, "R8 drained", 64'(out_valid_o), 64'h0);
    finish_run();
  end

endmodule